// File: doc/BRIEF.md
# Half-Precision Three-Operand Min / Max / Median Unit

This unit picks one of three binary16 floating-point operands. An operation code selects the smallest, the largest or the middle value. Each operand sits in the low half of a 32-bit source word, and the upper halves play no part. The unit does no arithmetic. It only orders operands and selects one of them, so no rounding or exception state is produced.

NaN operands are handled by a fixed priority. The operands are checked for NaN from source 0 upward, and the first NaN found is dropped. The two remaining operands are then combined by a two-input maximum or minimum. When no operand is NaN, strict comparisons decide the winner, so equal operands resolve to a fixed source. The selection is captured in a register one clock after an input strobe. A valid flag marks the new result.

Top module: `hmm3_unit`

## Requirements
- R1: While rst_ni is low and after its release, valid_o is 0 and result_o is 0 until the first strobe.
- R2: valid_o is 1 in exactly the cycle after a cycle with valid_i high, and 0 otherwise. result_o changes only on the edge that follows a strobe, and it holds its value between strobes.
- R3: Source bits 31:16 are ignored. result_o bits 31:16 are always 0, and the selected binary16 value appears in bits 15:0.
- R4: An operand is NaN when bits 14:10 are all ones and bits 9:0 are nonzero. Values with bits 14:10 all ones and zero mantissa are infinities and are ordered normally. The ordering is by sign and magnitude, and +0 equals -0.
- R5: With op_i = 1 (maximum) and no NaN, the result is source 2 only if source 2 is strictly greater than both others. Otherwise the result is the larger of source 1 and source 0.
- R6: With op_i = 0 (minimum) and no NaN, the result is source 2 only if source 2 is strictly less than both others. Otherwise the result is the smaller of source 1 and source 0.
- R7: With op_i = 2 (median) and no NaN, the result is source 2 if it lies strictly between source 1 and source 0. Failing that, it is source 1 if that lies strictly between source 2 and source 0. Otherwise it is source 0.
- R8: If any operand is NaN, the first NaN in the order source 0, source 1, source 2 is dropped. The remaining two operands are combined by a maximum for op_i = 1, and by a minimum for op_i = 0 or 2.
- R9: Ties resolve as follows. In the NaN-drop case, the lower-indexed remaining operand wins a tie. In the no-NaN maximum and minimum fallthrough, source 1 wins a tie with source 0.
- R10: If one of the two remaining operands is NaN, the two-input combine returns the other one. If both are NaN, it returns 0x7E00. The result is therefore NaN only when all three operands are NaN, and it is then 0x7E00.
- R11: op_i = 3 behaves exactly like op_i = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe |
| op_i | input | 2 | 0 minimum, 1 maximum, 2 or 3 median |
| src0_i | input | 32 | Operand 0, binary16 in bits 15:0 |
| src1_i | input | 32 | Operand 1, binary16 in bits 15:0 |
| src2_i | input | 32 | Operand 2, binary16 in bits 15:0 |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 32 | Selected value in bits 15:0, upper half zero |

## Verification
Ordered triples of distinct values show whether each operation picks the right position for every permutation. Triples built from +0 and -0 differ only in sign, so they separate the tie rules from a plain magnitude compare. Operands with one, two or three NaNs, placed in every source position, test the drop priority, the two-input fallback and the canonical NaN. Infinities and random words with garbage in the upper half confirm that infinities are not taken for NaN and that the upper half is ignored.

// File: rtl/hmm3_pkg.sv
package hmm3_pkg;
  localparam int HW    = 16;
  localparam int EXP_W = 5;
  localparam int MAN_W = 10;
  localparam int SRC_W = 32;
  localparam int NSRC  = 3;
  localparam logic [HW-1:0] QNAN = 16'h7E00;

  typedef enum logic [1:0] {
    OP_MIN  = 2'd0,
    OP_MAX  = 2'd1,
    OP_MED  = 2'd2,
    OP_MED3 = 2'd3
  } op_e;
endpackage

// File: rtl/fp16_order.sv
// Ordering of two non-NaN binary16 values; +0 == -0.
module fp16_order #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         lt_o,
  output logic         gt_o
);
  logic signed [W:0] ka, kb;
  logic        [W:0] ma, mb;

  assign ma = {2'b00, a_i[W-2:0]};
  assign mb = {2'b00, b_i[W-2:0]};
  assign ka = a_i[W-1] ? -$signed(ma) : $signed(ma);
  assign kb = b_i[W-1] ? -$signed(mb) : $signed(mb);
  assign lt_o = ka < kb;
  assign gt_o = ka > kb;
endmodule

// File: rtl/fp16_pick2.sv
// Two-input min/max with NaN fallback; x wins ties.
module fp16_pick2
  import hmm3_pkg::*;
(
  input  logic [HW-1:0] x_i,
  input  logic [HW-1:0] y_i,
  input  logic          x_nan_i,
  input  logic          y_nan_i,
  input  logic          x_lt_y_i,
  input  logic          x_gt_y_i,
  input  logic          max_i,
  output logic [HW-1:0] z_o
);
  always_comb begin
    if (x_nan_i && y_nan_i) z_o = QNAN;
    else if (x_nan_i)       z_o = y_i;
    else if (y_nan_i)       z_o = x_i;
    else if (max_i)         z_o = x_lt_y_i ? y_i : x_i;
    else                    z_o = x_gt_y_i ? y_i : x_i;
  end
endmodule

// File: rtl/hmm3_core.sv
module hmm3_core
  import hmm3_pkg::*;
(
  input  op_e           op_i,
  input  logic [HW-1:0] s0_i,
  input  logic [HW-1:0] s1_i,
  input  logic [HW-1:0] s2_i,
  output logic [HW-1:0] res_o
);
  localparam int NPAIR = 3;
  // pair p compares s[PA[p]] against s[PB[p]]
  localparam int PA [NPAIR] = '{0, 0, 1};
  localparam int PB [NPAIR] = '{1, 2, 2};

  logic [HW-1:0]    s   [NSRC];
  logic [NSRC-1:0]  nan;
  logic [NPAIR-1:0] lt, gt;
  logic [HW-1:0]    fb  [NPAIR];
  logic             want_max;

  assign s[0] = s0_i;
  assign s[1] = s1_i;
  assign s[2] = s2_i;
  assign want_max = (op_i == OP_MAX);

  for (genvar i = 0; i < NSRC; i++) begin : g_nan
    assign nan[i] = (&s[i][HW-2 -: EXP_W]) && (|s[i][MAN_W-1:0]);
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    fp16_order #(.W(HW)) u_ord (
      .a_i (s[PA[p]]),
      .b_i (s[PB[p]]),
      .lt_o(lt[p]),
      .gt_o(gt[p])
    );
    fp16_pick2 u_pick (
      .x_i     (s[PA[p]]),
      .y_i     (s[PB[p]]),
      .x_nan_i (nan[PA[p]]),
      .y_nan_i (nan[PB[p]]),
      .x_lt_y_i(lt[p]),
      .x_gt_y_i(gt[p]),
      .max_i   (want_max),
      .z_o     (fb[p])
    );
  end

  always_comb begin
    if (nan[0])      res_o = fb[2];  // drop s0 -> (s1,s2)
    else if (nan[1]) res_o = fb[1];  // drop s1 -> (s0,s2)
    else if (nan[2]) res_o = fb[0];  // drop s2 -> (s0,s1)
    else begin
      unique case (op_i)
        OP_MAX: begin
          if (lt[1] && lt[2]) res_o = s2_i;
          else                res_o = gt[0] ? s0_i : s1_i;
        end
        OP_MIN: begin
          if (gt[1] && gt[2]) res_o = s2_i;
          else                res_o = lt[0] ? s0_i : s1_i;
        end
        default: begin
          if ((lt[2] && gt[1]) || (gt[2] && lt[1]))      res_o = s2_i;
          else if ((gt[2] && gt[0]) || (lt[2] && lt[0])) res_o = s1_i;
          else                                           res_o = s0_i;
        end
      endcase
    end
  end
endmodule

// File: rtl/hmm3_unit.sv
module hmm3_unit
  import hmm3_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [1:0]  op_i,
  input  logic [31:0] src0_i,
  input  logic [31:0] src1_i,
  input  logic [31:0] src2_i,
  output logic        valid_o,
  output logic [31:0] result_o
);
  logic [HW-1:0] core_res, res_q;
  logic          valid_q;

  hmm3_core u_core (
    .op_i (op_e'(op_i)),
    .s0_i (src0_i[HW-1:0]),
    .s1_i (src1_i[HW-1:0]),
    .s2_i (src2_i[HW-1:0]),
    .res_o(core_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) res_q <= core_res;
    end
  end

  assign valid_o  = valid_q;
  assign result_o = {{(SRC_W-HW){1'b0}}, res_q};

  // checks
  function automatic logic is_nan16(input logic [HW-1:0] v);
    return (&v[14:10]) && (|v[9:0]);
  endfunction

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  a_r10_member: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (result_o[15:0] == $past(src0_i[15:0]) ||
                 result_o[15:0] == $past(src1_i[15:0]) ||
                 result_o[15:0] == $past(src2_i[15:0]) ||
                 result_o[15:0] == QNAN));
  a_r10_all_nan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_nan16(src0_i[15:0]) && is_nan16(src1_i[15:0]) && is_nan16(src2_i[15:0])
    |=> result_o[15:0] == QNAN);
  a_r10_nan_canon: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && is_nan16(result_o[15:0]) |-> result_o[15:0] == QNAN);
endmodule

// File: tb/tb_hmm3_unit.sv
`timescale 1ns/1ps
module tb_hmm3_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic [31:0] src0_i = '0, src1_i = '0, src2_i = '0;
  logic        valid_o;
  logic [31:0] result_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hmm3_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .src0_i(src0_i), .src1_i(src1_i), .src2_i(src2_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  // reference model from the requirements
  function automatic bit f_nan(input logic [15:0] v);
    return (v[14:10] == 5'h1F) && (v[9:0] != 0);
  endfunction
  function automatic int f_key(input logic [15:0] v);
    int m = int'(v[14:0]);
    return v[15] ? -m : m;
  endfunction
  function automatic logic [15:0] f_pick(input logic [15:0] x, input logic [15:0] y, input bit mx);
    if (f_nan(x) && f_nan(y)) return 16'h7E00;
    if (f_nan(x)) return y;
    if (f_nan(y)) return x;
    if (mx) return (f_key(y) > f_key(x)) ? y : x;
    return (f_key(y) < f_key(x)) ? y : x;
  endfunction
  function automatic logic [15:0] f_ref(input logic [1:0] op, input logic [15:0] a,
                                        input logic [15:0] b, input logic [15:0] c);
    bit mx = (op == 2'd1);
    int ka, kb, kc;
    if (f_nan(a)) return f_pick(b, c, mx);
    if (f_nan(b)) return f_pick(a, c, mx);
    if (f_nan(c)) return f_pick(a, b, mx);
    ka = f_key(a); kb = f_key(b); kc = f_key(c);
    if (op == 2'd1) return (kc > ka && kc > kb) ? c : ((ka > kb) ? a : b);
    if (op == 2'd0) return (kc < ka && kc < kb) ? c : ((ka < kb) ? a : b);
    if ((kc > kb && kc < ka) || (kc < kb && kc > ka)) return c;
    if ((kb > kc && kb < ka) || (kb < kc && kb > ka)) return b;
    return a;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive one strobe, check the result one cycle later, then check the hold
  task automatic run(input string tag, input logic [1:0] op, input logic [31:0] a,
                     input logic [31:0] b, input logic [31:0] c, input logic [15:0] exp);
    logic [31:0] held;
    @(negedge clk);
    op_i = op; src0_i = a; src1_i = b; src2_i = c; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    src0_i = $urandom; src1_i = $urandom; src2_i = $urandom;
    check({tag, " R2 valid"}, {31'd0, valid_o}, 32'd1);
    check(tag, result_o, {16'h0, exp});
    held = result_o;
    @(negedge clk);
    check("R2 valid low", {31'd0, valid_o}, 32'd0);
    check("R2 hold", result_o, held);
  endtask

  task automatic dref(input string tag, input logic [1:0] op, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] c, input logic [15:0] exp);
    check({tag, " model"}, {16'h0, f_ref(op, a[15:0], b[15:0], c[15:0])}, {16'h0, exp});
    run(tag, op, a, b, c, exp);
  endtask

  function automatic logic [15:0] gen_val();
    int r = int'($urandom % 8);
    case (r)
      0: return {1'($urandom), 5'h1F, 10'($urandom | 1)};
      1: return {1'($urandom), 15'h0};
      2: return {1'($urandom), 5'h1F, 10'h0};
      3: return {1'($urandom), 15'($urandom % 4) + 15'h3C00};
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    int seed_set;
    seed_set = $urandom(32'h0F16);
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, valid_o}, 32'd0);
    check("R1 reset result", result_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 post-reset valid", {31'd0, valid_o}, 32'd0);
    check("R1 post-reset result", result_o, 32'd0);

    // R5 max, R6 min, R7 median
    dref("R5 max s2", 2'd1, 32'h3C00, 32'h4000, 32'h4200, 16'h4200);
    dref("R5 max s0", 2'd1, 32'h4200, 32'h4000, 32'h3C00, 16'h4200);
    dref("R6 min neg", 2'd0, 32'h3C00, 32'hC000, 32'hBC00, 16'hC000);
    dref("R6 min s2", 2'd0, 32'h3C00, 32'h4000, 32'hBC00, 16'hBC00);
    dref("R7 med s2", 2'd2, 32'h4200, 32'h3C00, 32'h4000, 16'h4000);
    dref("R7 med s1", 2'd2, 32'h3C00, 32'h4000, 32'h4200, 16'h4000);
    dref("R7 med s0", 2'd2, 32'h4000, 32'h3C00, 32'h4200, 16'h4000);
    dref("R7 med tie", 2'd2, 32'h3C00, 32'h3C00, 32'h4000, 16'h3C00);
    // R9 tie rules with signed zeros (R4: +0 == -0)
    dref("R9 max tie s1", 2'd1, 32'h0000, 32'h8000, 32'h8000, 16'h8000);
    dref("R9 min tie s1", 2'd0, 32'h8000, 32'h0000, 32'h0000, 16'h0000);
    dref("R9 nan drop tie", 2'd1, 32'h7E01, 32'h0000, 32'h8000, 16'h0000);
    dref("R9 med zeros", 2'd2, 32'h8000, 32'h0000, 32'h8000, 16'h8000);
    // R4 infinities are ordered, not NaN
    dref("R4 inf max", 2'd1, 32'hFC00, 32'h7BFF, 32'h7C00, 16'h7C00);
    dref("R4 inf min", 2'd0, 32'h7C00, 32'hFC00, 32'h7BFF, 16'hFC00);
    // R8 NaN priority
    dref("R8 s0 nan max", 2'd1, 32'h7C01, 32'h3C00, 32'h4000, 16'h4000);
    dref("R8 s1 nan med", 2'd2, 32'h4200, 32'hFE00, 32'h3C00, 16'h3C00);
    dref("R8 s2 nan min", 2'd0, 32'h4200, 32'h3C00, 32'hFFFF, 16'h3C00);
    dref("R8 s1s2 nan max", 2'd1, 32'h3C00, 32'h7E00, 32'h7D00, 16'h3C00);
    // R10 two-input NaN fallback and canonical NaN
    dref("R10 s0s1 nan", 2'd1, 32'h7C01, 32'hFFFF, 32'hC000, 16'hC000);
    dref("R10 all nan", 2'd0, 32'h7C01, 32'hFFFF, 32'h7E55, 16'h7E00);
    // R11 op 3 equals median
    dref("R11 op3", 2'd3, 32'h4200, 32'h3C00, 32'h4000, 16'h4000);
    dref("R11 op3 nan", 2'd3, 32'h4200, 32'h7E00, 32'h3C00, 16'h3C00);
    // R3 upper bits ignored
    dref("R3 upper", 2'd1, 32'h7E01_3C00, 32'hFFFF_4000, 32'h7C01_3800, 16'h4000);

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a, b, c;
      logic [1:0] op;
      string tag;
      a = gen_val(); b = gen_val(); c = gen_val();
      if ($urandom % 5 == 0) b = a;
      if ($urandom % 5 == 0) c = b;
      op = 2'($urandom);
      if (f_nan(a) || f_nan(b) || f_nan(c)) tag = "R8 R10 random nan";
      else if (op == 2'd1) tag = "R5 random max";
      else if (op == 2'd0) tag = "R6 random min";
      else tag = "R7 R11 random med";
      run(tag, op, {16'($urandom), a}, {16'($urandom), b}, {16'($urandom), c}, f_ref(op, a, b, c));
    end

    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule